// File: doc/BRIEF.md
# Accumulator Readout Rounding Saturator

This block turns a 48-bit multiply-accumulate result into a 32-bit register word. It sits on the read path between the accumulators and the register file. A format select chooses one of three readings of the accumulator: signed fraction, signed integer or unsigned integer. In the fractional format, the mode bits pick the precision, the rounding and the saturation.

The fraction can be read at two precisions. At 16 bits, the low 24 bits of the accumulator form the remainder and are always rounded away, half to even. The 16-bit result is then sign-extended to 32 bits. At 32 bits, the low 8 bits form the remainder. They are either dropped or rounded half to even, as the rounding bit selects. With the overflow-mode bit set, a fractional value that does not fit its precision clamps to the largest positive or most negative code. With that bit clear, the low bits wrap. The integer readings always clamp.

The datapath itself is combinational. Its result is captured in one output register, so a readout appears one clock after its inputs.

Top module: `acc_readout`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` becomes 0 at that edge, whatever the other inputs are.
- R2: `result` after a rising edge is the function of `acc_in`, `fmt_sel`, `su`, `rt` and `omc` sampled at that edge. The latency is exactly one cycle.
- R3: With `fmt_sel` = 0 and `su` = 1, the value is `acc_in[47:24]` (signed). It is rounded half to even on the 24-bit remainder `acc_in[23:0]`, with midpoint 0x800000. `rt` has no effect.
- R4: With `fmt_sel` = 0, `su` = 0 and `rt` = 1, the value is `acc_in[47:8]` (signed). It is rounded half to even on `acc_in[7:0]`, with midpoint 0x80.
- R5: With `fmt_sel` = 0, `su` = 0 and `rt` = 0, the value is `acc_in` shifted right arithmetically by 8, with no rounding.
- R6: With `fmt_sel` = 0, `su` = 1 and `omc` = 1, a rounded value above 32767 gives 0x00007FFF. A rounded value below -32768 gives 0xFFFF8000.
- R7: With `fmt_sel` = 0, `su` = 0 and `omc` = 1, a rounded value outside the signed 32-bit range gives 0x7FFFFFFF when positive and 0x80000000 when negative.
- R8: With `fmt_sel` = 0 and `omc` = 0, the fractional result is the low 32 bits of the rounded value. In 16-bit precision it is the low 16 bits, sign-extended from bit 15.
- R9: With `fmt_sel` = 1, the signed 48-bit accumulator passes when it fits in signed 32 bits. Otherwise it gives 0x7FFFFFFF when positive and 0x80000000 when negative. `su`, `rt` and `omc` have no effect.
- R10: With `fmt_sel` = 2 or 3, `acc_in[31:0]` passes when `acc_in[47:32]` is zero. Otherwise the result is 0xFFFFFFFF. `su`, `rt` and `omc` have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_in | input | 48 | Accumulator value, two's complement |
| fmt_sel | input | 2 | 0 fractional, 1 signed integer, 2 or 3 unsigned integer |
| su | input | 1 | Fractional precision: 1 selects 16-bit, 0 selects 32-bit |
| rt | input | 1 | Rounding enable for 32-bit fractional readout |
| omc | input | 1 | Saturation enable for fractional readout |
| result | output | 32 | Registered readout word |

## Verification
The bench builds the block with its default widths: a 48-bit accumulator, 32-bit output, 16-bit narrow precision and an 8-bit guard field. At these sizes, directed vectors can place the exact rounding midpoints of both precisions (0x800000 and 0x80) under odd and even values. They can also reach the carry that rounding pushes past the largest positive code, which then saturates or wraps. Random vectors weighted toward ties, small signed values and the edges of the signed and unsigned ranges cover every combination of `fmt_sel`, `su`, `rt` and `omc`.

// File: rtl/acc_ro_pkg.sv
// Shared definitions for the accumulator readout path.
// Assumes a 2-bit format select in which codes 2 and 3 both mean unsigned.
package acc_ro_pkg;
    typedef enum logic [1:0] {
        RO_FRAC     = 2'd0,
        RO_SINT     = 2'd1,
        RO_UINT     = 2'd2,
        RO_UINT_ALT = 2'd3
    } ro_fmt_e;
endpackage

// File: rtl/ro_rne_round.sv
// Round-half-to-even stage. It adds one to an unsigned-encoded two's
// complement quotient when the remainder lies above the midpoint, or
// exactly at the midpoint with an odd quotient. The output is one bit
// wider than the quotient, so the increment can never wrap.
// Assumes REM_W >= 1.
module ro_rne_round #(
    parameter int Q_W   = 24,
    parameter int REM_W = 24
) (
    input  logic [Q_W-1:0]   q_in,
    input  logic [REM_W-1:0] rem_in,
    input  logic             en,
    output logic [Q_W:0]     q_out
);
    localparam logic [REM_W-1:0] HALF = {1'b1, {(REM_W-1){1'b0}}};

    logic inc;

    // Decide on the increment and form the sign-extended sum.
    always_comb begin
        inc   = en && ((rem_in > HALF) || ((rem_in == HALF) && q_in[0]));
        q_out = {q_in[Q_W-1], q_in} + {{Q_W{1'b0}}, inc};
    end
endmodule

// File: rtl/ro_sat_clamp.sv
// Signed narrowing with an optional clamp. The input fits when every bit
// from the top down to output bit OUT_W-1 agrees. When it does not fit
// and sat_en is high, the output becomes the extreme code with the input's
// sign. Otherwise the low OUT_W bits pass through.
// Assumes IN_W > OUT_W.
module ro_sat_clamp #(
    parameter int IN_W  = 48,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_in,
    input  logic             sat_en,
    output logic [OUT_W-1:0] val_out
);
    localparam int HI_W = IN_W - OUT_W + 1;

    logic [HI_W-1:0] hi_bits;
    logic            fits;

    // Test the range and choose between pass-through and the clamp code.
    always_comb begin
        hi_bits = val_in[IN_W-1:OUT_W-1];
        fits    = (&hi_bits) || !(|hi_bits);
        if (sat_en && !fits)
            val_out = val_in[IN_W-1] ? {1'b1, {(OUT_W-1){1'b0}}}
                                     : {1'b0, {(OUT_W-1){1'b1}}};
        else
            val_out = val_in[OUT_W-1:0];
    end
endmodule

// File: rtl/acc_readout.sv
// Accumulator readout: fractional (16/32-bit precision), signed integer or
// unsigned integer conversion of a two's complement accumulator into an
// OUT_W-bit word, registered once. Assumes ACC_W > OUT_W + GUARD_W and
// that GUARD_W + NARROW_W < ACC_W.
module acc_readout
    import acc_ro_pkg::*;
#(
    parameter int ACC_W    = 48,
    parameter int OUT_W    = 32,
    parameter int NARROW_W = 16,
    parameter int GUARD_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_in,
    input  logic [1:0]       fmt_sel,
    input  logic             su,
    input  logic             rt,
    input  logic             omc,
    output logic [OUT_W-1:0] result
);
    localparam int NRW_REM_W = GUARD_W + NARROW_W;
    localparam int NRW_Q_W   = ACC_W - NRW_REM_W;
    localparam int WIDE_Q_W  = ACC_W - GUARD_W;
    localparam int EXT_W     = OUT_W - NARROW_W;

    logic [NRW_Q_W:0]    nrw_rnd;
    logic [WIDE_Q_W:0]   wide_rnd;
    logic [NARROW_W-1:0] nrw_sat;
    logic [OUT_W-1:0]    wide_sat;
    logic [OUT_W-1:0]    sint_sat;
    logic [OUT_W-1:0]    uint_val;
    logic [OUT_W-1:0]    nrw_ext;
    logic [OUT_W-1:0]    next_word;
    ro_fmt_e             fmt;

    // Narrow fraction: the remainder is always rounded away.
    ro_rne_round #(.Q_W(NRW_Q_W), .REM_W(NRW_REM_W)) u_rnd_nrw (
        .q_in   (acc_in[ACC_W-1:NRW_REM_W]),
        .rem_in (acc_in[NRW_REM_W-1:0]),
        .en     (1'b1),
        .q_out  (nrw_rnd)
    );

    ro_sat_clamp #(.IN_W(NRW_Q_W + 1), .OUT_W(NARROW_W)) u_sat_nrw (
        .val_in  (nrw_rnd),
        .sat_en  (omc),
        .val_out (nrw_sat)
    );

    // Wide fraction: rounding is optional and drops GUARD_W bits.
    ro_rne_round #(.Q_W(WIDE_Q_W), .REM_W(GUARD_W)) u_rnd_wide (
        .q_in   (acc_in[ACC_W-1:GUARD_W]),
        .rem_in (acc_in[GUARD_W-1:0]),
        .en     (rt),
        .q_out  (wide_rnd)
    );

    ro_sat_clamp #(.IN_W(WIDE_Q_W + 1), .OUT_W(OUT_W)) u_sat_wide (
        .val_in  (wide_rnd),
        .sat_en  (omc),
        .val_out (wide_sat)
    );

    // Signed integer: clamping is unconditional.
    ro_sat_clamp #(.IN_W(ACC_W), .OUT_W(OUT_W)) u_sat_sint (
        .val_in  (acc_in),
        .sat_en  (1'b1),
        .val_out (sint_sat)
    );

    // Sign-extend the narrow fraction to the output width.
    generate
        if (EXT_W > 0) begin : g_ext
            assign nrw_ext = {{EXT_W{nrw_sat[NARROW_W-1]}}, nrw_sat};
        end else begin : g_noext
            assign nrw_ext = nrw_sat[OUT_W-1:0];
        end
    endgenerate

    // Unsigned integer: saturate to all ones when any upper bit is set.
    always_comb begin
        uint_val = (|acc_in[ACC_W-1:OUT_W]) ? {OUT_W{1'b1}} : acc_in[OUT_W-1:0];
    end

    // Choose the word for the selected format and precision.
    always_comb begin
        fmt = ro_fmt_e'(fmt_sel);
        unique case (fmt)
            RO_FRAC:              next_word = su ? nrw_ext : wide_sat;
            RO_SINT:              next_word = sint_sat;
            RO_UINT, RO_UINT_ALT: next_word = uint_val;
            default:              next_word = uint_val;
        endcase
    end

    // Capture the readout word; clear it under reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            result <= '0;
        else
            result <= next_word;
    end
endmodule

// File: rtl/acc_readout_chk.sv
// Property checker for acc_readout, attached by bind. It relates the
// sampled inputs to the registered result one cycle later.
module acc_readout_chk #(
    parameter int ACC_W   = 48,
    parameter int OUT_W   = 32,
    parameter int GUARD_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [ACC_W-1:0] acc_in,
    input logic [1:0]       fmt_sel,
    input logic             su,
    input logic             rt,
    input logic             omc,
    input logic [OUT_W-1:0] result
);
    localparam int HI_W = ACC_W - OUT_W + 1;

    logic [HI_W-1:0] hi;
    logic            in_range;

    // Range of the raw accumulator against the signed output width.
    always_comb begin
        hi       = acc_in[ACC_W-1:OUT_W-1];
        in_range = (&hi) || !(|hi);
    end

    // R1: reset clears the word
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (result == '0));

    // R5: the truncating wide fraction is the shifted accumulator
    a_r5_trunc_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 2'd0 && !su && !rt && !omc)
        |=> (result == $past(acc_in[OUT_W+GUARD_W-1:GUARD_W])));

    // R8: the narrow fraction is sign-extended
    a_r8_narrow_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 2'd0 && su)
        |=> ((&result[OUT_W-1:15]) || !(|result[OUT_W-1:15])));

    // R7: a wide fraction far below range clamps negative
    a_r7_wide_neg_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 2'd0 && !su && omc && acc_in[ACC_W-1]
         && !(&acc_in[ACC_W-1:OUT_W+GUARD_W-1]))
        |=> (result == {1'b1, {(OUT_W-1){1'b0}}}));

    // R9: a signed integer out of range clamps by sign
    a_r9_sint_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 2'd1 && !in_range)
        |=> (result == ($past(acc_in[ACC_W-1]) ? {1'b1, {(OUT_W-1){1'b0}}}
                                               : {1'b0, {(OUT_W-1){1'b1}}})));

    // R10: an unsigned integer with upper bits set gives all ones
    a_r10_uint_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel[1] && (|acc_in[ACC_W-1:OUT_W]))
        |=> (result == {OUT_W{1'b1}}));
endmodule

bind acc_readout acc_readout_chk #(
    .ACC_W   (ACC_W),
    .OUT_W   (OUT_W),
    .GUARD_W (GUARD_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_in  (acc_in),
    .fmt_sel (fmt_sel),
    .su      (su),
    .rt      (rt),
    .omc     (omc),
    .result  (result)
);

// File: tb/sim_acc_readout.sv
module sim_acc_readout;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [47:0] acc_in;
    logic [1:0]  fmt_sel;
    logic        su, rt, omc;
    logic [31:0] result;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #2 clk = ~clk;

    acc_readout u0 (
        .clk(clk), .rst_n(rst_n), .acc_in(acc_in), .fmt_sel(fmt_sel),
        .su(su), .rt(rt), .omc(omc), .result(result)
    );

    // Behavioural reference built from the requirements.
    function automatic logic [31:0] model(logic [47:0] a48, logic [1:0] f,
                                          bit s, bit r, bit o);
        longint a, q, rem;
        a = longint'($signed(a48));
        if (f == 2'd0) begin
            if (s) begin
                q = a >>> 24;
                rem = a & 64'hFFFFFF;
                if (rem > 64'h800000 || (rem == 64'h800000 && q[0])) q = q + 1;
                if (o && q > 32767) return 32'h0000_7FFF;
                if (o && q < -32768) return 32'hFFFF_8000;
                return {{16{q[15]}}, q[15:0]};
            end
            q = a >>> 8;
            rem = a & 64'hFF;
            if (r && (rem > 64'h80 || (rem == 64'h80 && q[0]))) q = q + 1;
            if (o && q > 64'sd2147483647) return 32'h7FFF_FFFF;
            if (o && q < -64'sd2147483648) return 32'h8000_0000;
            return q[31:0];
        end
        if (f == 2'd1) begin
            if (a > 64'sd2147483647) return 32'h7FFF_FFFF;
            if (a < -64'sd2147483648) return 32'h8000_0000;
            return a[31:0];
        end
        if (a48[47:32] != 16'h0) return 32'hFFFF_FFFF;
        return a48[31:0];
    endfunction

    function automatic string req_tag(logic [1:0] f, bit s, bit r, bit o);
        if (f == 2'd1) return "R9";
        if (f[1]) return "R10";
        if (!o) return s ? "R3/R8" : (r ? "R4/R8" : "R5/R8");
        if (s) return "R3/R6";
        return r ? "R4/R7" : "R5/R7";
    endfunction

    // Drive one vector, then compare one clock later (R2 latency).
    task automatic apply(logic [47:0] a, logic [1:0] f, bit s, bit r, bit o);
        logic [31:0] exp;
        acc_in = a; fmt_sel = f; su = s; rt = r; omc = o;
        exp = model(a, f, s, r, o);
        @(negedge clk);
        vectors++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s R2 acc=%h fmt=%0d su=%0b rt=%0b omc=%0b got=%h exp=%h",
                     req_tag(f, s, r, o), a, f, s, r, o, result, exp);
        end
    endtask

    initial begin
        rst_n = 1'b0; acc_in = 48'hFFFF_FFFF_FFFF; fmt_sel = 2'd2;
        su = 1'b1; rt = 1'b1; omc = 1'b1;
        repeat (3) @(negedge clk);
        vectors++; // R1
        if (result !== 32'h0) begin
            errors++;
            $display("FAIL R1 got=%h exp=%h", result, 32'h0);
        end
        rst_n = 1'b1;
        // R3: 16-bit ties, odd rounds up, even stays; RT has no effect
        apply(48'h000001_800000, 2'd0, 1, 0, 0);
        apply(48'h000002_800000, 2'd0, 1, 1, 0);
        apply(48'h000002_800001, 2'd0, 1, 0, 1);
        apply(48'hFFFFFF_800000, 2'd0, 1, 0, 1);
        // R4: 32-bit ties
        apply(48'h0000_0000_0180, 2'd0, 0, 1, 0);
        apply(48'h0000_0000_0280, 2'd0, 0, 1, 0);
        apply(48'h0000_0000_027F, 2'd0, 0, 1, 0);
        // R5: truncation, including negative
        apply(48'h0000_0000_01FF, 2'd0, 0, 0, 0);
        apply(48'hFFFF_FFFF_FE01, 2'd0, 0, 0, 1);
        // R6: rounding carry past the top, clamp and wrap (R8)
        apply(48'h007FFF_FFFFFF, 2'd0, 1, 0, 1);
        apply(48'h007FFF_FFFFFF, 2'd0, 1, 0, 0);
        apply(48'hFF0000_000000, 2'd0, 1, 0, 1);
        // R7: wide clamps both ways, wrap with OMC clear (R8)
        apply(48'h7F00_0000_0000, 2'd0, 0, 1, 1);
        apply(48'h8000_0000_0000, 2'd0, 0, 0, 1);
        apply(48'h007F_FFFF_FFFF, 2'd0, 0, 1, 1);
        apply(48'h0100_0000_0000, 2'd0, 0, 0, 0);
        // R9: signed integer edges, mode bits ignored
        apply(48'h0000_7FFF_FFFF, 2'd1, 1, 1, 0);
        apply(48'h0000_8000_0000, 2'd1, 0, 0, 0);
        apply(48'hFFFF_8000_0000, 2'd1, 1, 0, 1);
        apply(48'hFFFF_7FFF_FFFF, 2'd1, 0, 1, 0);
        // R10: unsigned edges, both codes
        apply(48'h0000_FFFF_FFFF, 2'd2, 1, 1, 1);
        apply(48'h0001_0000_0000, 2'd3, 0, 0, 0);
        apply(48'hFFFF_FFFF_FFFF, 2'd2, 0, 0, 0);
        for (int i = 0; i < 600; i++) begin
            logic [47:0] a;
            int k;
            a = {$urandom(), $urandom()};
            k = $urandom % 4;
            if (k == 1) a = {{16{a[31]}}, a[31:0]} >>> ($urandom % 24);
            if (k == 2) begin
                if ($urandom % 2) a[23:0] = 24'h800000;
                else a[7:0] = 8'h80;
            end
            if (k == 3) a = {{8{a[47]}}, a[47:40] == 8'h0 ? 8'h7F : 8'h80,
                             a[31:0] | 32'hFFFF_FF00};
            apply(a, 2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule